// File: doc/BRIEF.md
# Set/Clear Event and Mask Register Block

This block holds a five-bit event register and a five-bit mask register on a simple register bus. Software never needs a read-modify-write cycle to change either register. Each register has one address where every 1 in the write data sets the matching bit, and a second address where every 1 clears it. A 0 in the write data leaves that bit alone.

Hardware raises the event bits. Two of them latch error strobes from a serial EEPROM loader: a missing acknowledge and a CRC failure. The other three latch a change of bit 15 on one of three 16-bit counters that the block owns. Software can load each counter over the bus, and each counter also has an increment strobe. A change of bit 15 in either direction raises the event, whether an increment or a bus write caused it.

A single interrupt output is high when any event bit is set together with its mask bit. The output is registered.

Top module: `sc_event_regs`

## Requirements
- R1: A write to 0x04 sets every event bit whose write-data bit is 1, and a write to 0x08 clears every event bit whose write-data bit is 1. Event bits whose write-data bit is 0 keep their value.
- R2: A write to 0x0C sets mask bits and a write to 0x10 clears mask bits, with the same per-bit write-one rule as R1.
- R3: Reading 0x04 returns the raw event bits and reading 0x08 returns event AND mask. Reading either 0x0C or 0x10 returns the mask. Bits 31:5 of all these reads are 0.
- R4: While reset is asserted, the event register, the mask register, the three counters and the interrupt output are all 0.
- R5: An EEPROM acknowledge-error strobe sets event bit 4. An EEPROM CRC-error strobe sets event bit 3.
- R6: A write to 0x40, 0x44 or 0x48 loads counter 0, 1 or 2 from write-data bits 15:0. An increment strobe adds 1 to its counter, and the counter wraps from 0xFFFF to 0. If a write and an increment reach the same counter in one cycle, the write wins. A counter reads back zero-extended at its own address.
- R7: A change of bit 15 of counter k (k = 0, 1, 2), rising or falling and caused by an increment or a write, sets event bit k on the clock edge after the edge that changed the counter.
- R8: If a hardware set and a software clear reach the same event bit in the same cycle, the bit ends up set.
- R9: The interrupt output equals the OR over bits 4:0 of (event AND mask) as it stood one clock earlier.
- R10: Reads at any address other than 0x04, 0x08, 0x0C, 0x10, 0x40, 0x44 and 0x48 return 0. Writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe, takes effect on the clock edge |
| bus_addr_i | input | 8 | Byte address for reads and writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| ee_ack_err_i | input | 1 | EEPROM loader missing-acknowledge strobe |
| ee_crc_err_i | input | 1 | EEPROM loader CRC-error strobe |
| cnt_inc_i | input | 3 | Increment strobes, bit k for counter k |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Some rules are checked by the assertions on every cycle:
- the one-cycle interrupt latency;
- hardware set winning over a clear;
- clears taking effect;
- counter loads and increments;
- any change of bit 15 being followed by the matching event bit;
- unmapped reads returning zero.

Other behaviour shows only in the bench's scenarios:
- the exact read value at each address, including the masked view at the clear address;
- writes of 0 bits leaving state alone;
- the extra cycle between a counter crossing and its event appearing;
- a falling crossing made by a software write;
- the wrap from 0xFFFF;
- a reset in the middle of activity.

// File: rtl/sc_evt_pkg.sv
package sc_evt_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int EVT_W   = 5;
  localparam int CNT_W   = 16;
  localparam int NUM_CNT = 3;

  localparam int OFF_EVT_SET = 'h04;
  localparam int OFF_EVT_CLR = 'h08;
  localparam int OFF_MSK_SET = 'h0C;
  localparam int OFF_MSK_CLR = 'h10;
  localparam int OFF_CNT0    = 'h40;
  localparam int CNT_STRIDE  = 4;

  // event bit positions; counter k drives bit k
  localparam int BIT_CRC = 3;
  localparam int BIT_ACK = 4;
endpackage

// File: rtl/sc_setclr_reg.sv
module sc_setclr_reg #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sw_set_i,
  input  logic [W-1:0] sw_clr_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;

  // hardware set is or-ed in last so it overrides a same-cycle clear
  always_comb q_d = (q_q & ~sw_clr_i) | sw_set_i | hw_set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  AST_HW_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_set_i != '0) |=> ((q_o & $past(hw_set_i)) == $past(hw_set_i))); // R8

  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sw_clr_i & ~hw_set_i & ~sw_set_i) != '0)
      |=> ((q_o & $past(sw_clr_i & ~hw_set_i & ~sw_set_i)) == '0)); // R1

  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_set_i != '0) |=> ((q_o & $past(sw_set_i)) == $past(sw_set_i))); // R2
endmodule

// File: rtl/sc_toggle_cnt.sv
module sc_toggle_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         toggle_o
);
  logic [W-1:0] cnt_q;
  logic         msb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_en_i) cnt_q <= wr_data_i;
    else if (inc_i)   cnt_q <= cnt_q + W'(1);
  end

  // previous-cycle copy of the top bit; mismatch flags a crossing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) msb_q <= 1'b0;
    else         msb_q <= cnt_q[W-1];
  end

  assign cnt_o    = cnt_q;
  assign toggle_o = cnt_q[W-1] ^ msb_q;

  AST_CNT_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_en_i) |=> (cnt_o == $past(cnt_o) + W'(1))); // R6

  AST_CNT_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (cnt_o == $past(wr_data_i))); // R6
endmodule

// File: rtl/sc_event_regs.sv
module sc_event_regs
  import sc_evt_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int EW = EVT_W,
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          ee_ack_err_i,
  input  logic          ee_crc_err_i,
  input  logic [NUM_CNT-1:0] cnt_inc_i,
  output logic          irq_o
);
  localparam logic [AW-1:0] A_EVT_SET = AW'(OFF_EVT_SET);
  localparam logic [AW-1:0] A_EVT_CLR = AW'(OFF_EVT_CLR);
  localparam logic [AW-1:0] A_MSK_SET = AW'(OFF_MSK_SET);
  localparam logic [AW-1:0] A_MSK_CLR = AW'(OFF_MSK_CLR);

  logic          hit_evt_set, hit_evt_clr, hit_msk_set, hit_msk_clr;
  logic [NUM_CNT-1:0] hit_cnt;
  logic [EW-1:0] wbits;
  logic [EW-1:0] evt_q, mask_q, evt_hw;
  logic [NUM_CNT-1:0] toggle;
  logic [CW-1:0] cnt_w [NUM_CNT];
  logic          irq_q;

  assign hit_evt_set = bus_addr_i == A_EVT_SET;
  assign hit_evt_clr = bus_addr_i == A_EVT_CLR;
  assign hit_msk_set = bus_addr_i == A_MSK_SET;
  assign hit_msk_clr = bus_addr_i == A_MSK_CLR;
  assign wbits       = bus_wdata_i[EW-1:0];

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    localparam logic [AW-1:0] A_CNT = AW'(OFF_CNT0 + CNT_STRIDE * k);
    assign hit_cnt[k] = bus_addr_i == A_CNT;

    sc_toggle_cnt #(.W(CW)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (bus_wr_i && hit_cnt[k]),
      .wr_data_i (bus_wdata_i[CW-1:0]),
      .inc_i     (cnt_inc_i[k]),
      .cnt_o     (cnt_w[k]),
      .toggle_o  (toggle[k])
    );

    AST_TOGGLE_SETS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_w[k][CW-1] != $past(cnt_w[k][CW-1])) |=> evt_q[k]); // R7
  end

  always_comb begin
    evt_hw = '0;
    evt_hw[NUM_CNT-1:0] = toggle;
    evt_hw[BIT_CRC]     = ee_crc_err_i;
    evt_hw[BIT_ACK]     = ee_ack_err_i;
  end

  sc_setclr_reg #(.W(EW)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_set_i (wbits & {EW{bus_wr_i && hit_evt_set}}),
    .sw_clr_i (wbits & {EW{bus_wr_i && hit_evt_clr}}),
    .hw_set_i (evt_hw),
    .q_o      (evt_q)
  );

  sc_setclr_reg #(.W(EW)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_set_i (wbits & {EW{bus_wr_i && hit_msk_set}}),
    .sw_clr_i (wbits & {EW{bus_wr_i && hit_msk_clr}}),
    .hw_set_i ('0),
    .q_o      (mask_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(evt_q & mask_q);
  end
  assign irq_o = irq_q;

  always_comb begin
    bus_rdata_o = '0;
    if (hit_evt_set)                     bus_rdata_o = DW'(evt_q);
    else if (hit_evt_clr)                bus_rdata_o = DW'(evt_q & mask_q);
    else if (hit_msk_set || hit_msk_clr) bus_rdata_o = DW'(mask_q);
    for (int k = 0; k < NUM_CNT; k++)
      if (hit_cnt[k]) bus_rdata_o = DW'(cnt_w[k]);
  end

  AST_IRQ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(evt_q & mask_q)))); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_evt_set || hit_evt_clr || hit_msk_set || hit_msk_clr || (|hit_cnt))
      |-> (bus_rdata_o == '0)); // R10

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_evt_set || hit_evt_clr || hit_msk_set || hit_msk_clr)
      |-> (bus_rdata_o[DW-1:EW] == '0)); // R3
endmodule

// File: tb/sc_event_regs_tb.sv
module sc_event_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack = 1'b0, crc = 1'b0;
  logic [2:0]  inc = '0;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  sc_event_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ee_ack_err_i(ack),
    .ee_crc_err_i(crc), .cnt_inc_i(inc), .irq_o(irq)
  );

  // {req, wr, addr, wdata, expected read}
  localparam int NV = 27;
  localparam logic [76:0] VEC [NV] = '{
    {4'd2,  1'b1, 8'h0C, 32'h0000_0005, 32'h0},        // R2
    {4'd2,  1'b0, 8'h0C, 32'h0,         32'h0000_0005},
    {4'd1,  1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0},        // R1
    {4'd3,  1'b0, 8'h04, 32'h0,         32'h0000_001F}, // R3 reserved zero
    {4'd3,  1'b0, 8'h08, 32'h0,         32'h0000_0005},
    {4'd1,  1'b1, 8'h08, 32'h0000_0003, 32'h0},
    {4'd1,  1'b0, 8'h04, 32'h0,         32'h0000_001C},
    {4'd3,  1'b0, 8'h08, 32'h0,         32'h0000_0004},
    {4'd2,  1'b1, 8'h10, 32'h0000_0004, 32'h0},
    {4'd3,  1'b0, 8'h10, 32'h0,         32'h0000_0001},
    {4'd3,  1'b0, 8'h08, 32'h0,         32'h0000_0000},
    {4'd1,  1'b1, 8'h08, 32'h0000_001C, 32'h0},
    {4'd1,  1'b0, 8'h04, 32'h0,         32'h0000_0000},
    {4'd6,  1'b1, 8'h40, 32'h0000_1234, 32'h0},        // R6
    {4'd6,  1'b0, 8'h40, 32'h0,         32'h0000_1234},
    {4'd7,  1'b0, 8'h04, 32'h0,         32'h0000_0000}, // R7 no crossing
    {4'd10, 1'b0, 8'h20, 32'h0,         32'h0000_0000}, // R10
    {4'd10, 1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0},
    {4'd10, 1'b0, 8'h04, 32'h0,         32'h0000_0000},
    {4'd10, 1'b0, 8'h0C, 32'h0,         32'h0000_0001},
    {4'd7,  1'b1, 8'h44, 32'hFFFF_8000, 32'h0},
    {4'd6,  1'b0, 8'h44, 32'h0,         32'h0000_8000},
    {4'd7,  1'b0, 8'h04, 32'h0,         32'h0000_0002},
    {4'd1,  1'b1, 8'h08, 32'h0000_0002, 32'h0},
    {4'd1,  1'b0, 8'h04, 32'h0,         32'h0000_0000},
    {4'd2,  1'b1, 8'h0C, 32'h0000_0002, 32'h0},
    {4'd2,  1'b0, 8'h0C, 32'h0,         32'h0000_0003}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #2;
    chk(req, rdata, exp);
  endtask

  task automatic wr_bus(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R4 reset state
    rd("R4", 8'h04, 32'h0);
    rd("R4", 8'h0C, 32'h0);
    rd("R4", 8'h40, 32'h0);
    chk("R4", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  v_req;
      logic        v_wr;
      logic [7:0]  v_a;
      logic [31:0] v_d, v_e;
      @(negedge clk);
      {v_req, v_wr, v_a, v_d, v_e} = VEC[i];
      wr = v_wr; addr = v_a; wdata = v_d;
      if (!v_wr) begin
        #2;
        chk($sformatf("R%0d vec %0d", v_req, i), rdata, v_e);
      end
    end
    @(negedge clk); wr = 1'b0;
    wr_bus(8'h10, 32'h1F);

    // R5 EEPROM strobes
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    rd("R5", 8'h04, 32'h10);
    @(negedge clk); crc = 1'b1;
    @(negedge clk); crc = 1'b0;
    rd("R5", 8'h04, 32'h18);
    chk("R9", {31'h0, irq}, 32'h0);
    wr_bus(8'h08, 32'h1F);

    // R9 interrupt timing
    wr_bus(8'h0C, 32'h10);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R9", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R9", {31'h0, irq}, 32'h1);
    wr_bus(8'h08, 32'h10);
    chk("R9", {31'h0, irq}, 32'h1);
    @(negedge clk);
    chk("R9", {31'h0, irq}, 32'h0);

    // R8 hardware set beats same-cycle clear
    @(negedge clk); ack = 1'b1; wr = 1'b1; addr = 8'h08; wdata = 32'h10;
    @(negedge clk); ack = 1'b0; wr = 1'b0;
    rd("R8", 8'h04, 32'h10);
    wr_bus(8'h08, 32'h1F);
    wr_bus(8'h10, 32'h1F);
    rd("R1", 8'h04, 32'h0);

    // R6 R7 increments across bit 15
    wr_bus(8'h48, 32'h7FFE);
    @(negedge clk); inc = 3'b100;
    @(negedge clk);
    @(negedge clk); inc = 3'b000;
    rd("R6", 8'h48, 32'h8000);
    rd("R7", 8'h04, 32'h0);
    @(negedge clk);
    rd("R7", 8'h04, 32'h4);

    // R6 write wins over increment
    @(negedge clk); wr = 1'b1; addr = 8'h40; wdata = 32'h5; inc = 3'b001;
    @(negedge clk); wr = 1'b0; inc = 3'b000;
    rd("R6", 8'h40, 32'h5);

    // R7 falling crossing by software write
    wr_bus(8'h08, 32'h1F);
    wr_bus(8'h48, 32'h0);
    @(negedge clk);
    rd("R7", 8'h04, 32'h4);

    // R6 wrap, R7 rising then falling on counter 0
    wr_bus(8'h08, 32'h1F);
    wr_bus(8'h40, 32'hFFFF);
    @(negedge clk);
    rd("R7", 8'h04, 32'h1);
    wr_bus(8'h08, 32'h1F);
    rd("R1", 8'h04, 32'h0);
    @(negedge clk); inc = 3'b001;
    @(negedge clk); inc = 3'b000;
    rd("R6", 8'h40, 32'h0);
    @(negedge clk);
    rd("R7", 8'h04, 32'h1);

    // R4 reset in mid-run
    wr_bus(8'h0C, 32'h1F);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    rd("R4", 8'h04, 32'h0);
    rd("R4", 8'h0C, 32'h0);
    rd("R4", 8'h44, 32'h0);
    chk("R4", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R4", 8'h48, 32'h0);

    finish_run();
  end
endmodule